// File: doc/BRIEF.md
# Phase-Enable Clock Synthesizer Sequencer

This block drives a digital clock synthesizer that builds its output clock from four equally spaced reference phases of a VCO. Once per VCO period it presents a 4-bit phase-enable word. Bit k set means that phase k contributes an edge to the synthesized clock in that period. The output frequency is set by a ratio of N output edges per M VCO periods. An accumulator advances by N in each quarter-period slot and wraps at 4M. Each wrap enables the phase of that slot, so the N edges are spread as evenly as the slot grid allows and the pattern repeats every M periods.

Software writes a new ratio with a one-cycle write strobe. A legal ratio is held as pending and replaces the active one at the next sequence boundary, so generation never pauses and the sequence in progress is never cut short. A write in the last period of a sequence takes effect in the very next period. Illegal ratios are dropped and raise an error flag. A behavioural combiner reports how many output edges the enabled phases produce in each period. A sequence-start marker flags the first period of every sequence.

The control logic has two states. ST_STEADY means no ratio is pending. ST_ARMED means a legal ratio is waiting for the boundary. A legal write outside the last period moves ST_STEADY to ST_ARMED. The last period of a sequence moves ST_ARMED back to ST_STEADY as the pending ratio loads. A legal write in the last period loads at once and stays in ST_STEADY. A legal write in ST_ARMED replaces the pending ratio and stays in ST_ARMED.

Top module: `phase_seq_synth`

## Requirements
- R1: After reset the active ratio is RST_NUM/RST_DEN (default 2 edges per 1 period). The accumulator is zero, `seq_first` is high in the first period and `cfg_err` is low, so the first word is 4'b1010.
- R2: In each period, bit k of `phase_en` (k = 0..3) is set exactly when global slot s = 4p + k satisfies floor((s+1)N/4M) > floor(sN/4M), where p is the period index within the sequence. With 3/2 the words are 4'b0100 then 4'b1010. With 5/3 they are 4'b0100, 4'b1001 and 4'b1010.
- R3: Over every complete sequence of M periods the total number of set enable bits equals N.
- R4: `seq_first` is high in exactly the first period of each sequence, which is every M-th period.
- R5: A legal write takes effect from the first period of the next sequence. Until then the old pattern continues with no missing or shortened period. A write in the last period of a sequence takes effect in the next period.
- R6: A write with a zero denominator, or with N greater than 4M, sets `cfg_err` on the next cycle and is otherwise ignored. The active and pending ratios are unchanged. N = 4M is legal.
- R7: A legal write clears `cfg_err` on the next cycle.
- R8: A second legal write before the boundary replaces the first pending ratio, and only the second one takes effect.
- R9: `edge_cnt` equals the number of phases enabled in the current period, which is the number of edges the combined clock carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-period clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | One-cycle ratio write strobe |
| cfg_num | input | NW | Edges per sequence (N) |
| cfg_den | input | DW | VCO periods per sequence (M) |
| phase_en | output | 4 | Per-period phase enables, bit k for phase k |
| seq_first | output | 1 | High in the first period of a sequence |
| cfg_err | output | 1 | Last write was illegal |
| edge_cnt | output | 3 | Output edges produced in this period |

## Verification
The assertions assume that the write fields are meaningful only while the strobe is high. They also assume the strobe is a single-cycle pulse driven away from the clock edge. The stimulus always raises `cfg_we` for exactly one cycle, with the ratio fields stable across that edge. Illegal ratios are sent only from ST_STEADY, so whether the active ratio survived can be measured over the next full sequence. Every legal ratio in the stimulus keeps N at most 4M and M nonzero, which keeps the accumulator below 4M.

// File: rtl/phsq_pkg.sv
package phsq_pkg;
    localparam int NPH = 4;

    typedef enum logic [0:0] {
        ST_STEADY = 1'b0,
        ST_ARMED  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/phsq_stepper.sv
module phsq_stepper
    import phsq_pkg::*;
#(
    parameter int NW = 8,
    parameter int AW = 11
) (
    input  logic [AW-1:0]  acc_in,
    input  logic [NW-1:0]  num,
    input  logic [AW-1:0]  span,
    output logic [NPH-1:0] en,
    output logic [AW-1:0]  acc_out
);
    logic [AW-1:0] chain [0:NPH];

    assign chain[0] = acc_in;

    for (genvar k = 0; k < NPH; k++) begin : g_slot
        logic [AW-1:0] sum;
        assign sum          = chain[k] + AW'(num);
        assign en[k]        = (sum >= span);
        assign chain[k+1]   = en[k] ? (sum - span) : sum;
    end

    assign acc_out = chain[NPH];
endmodule

// File: rtl/phsq_combiner.sv
module phsq_combiner
    import phsq_pkg::*;
#(
    parameter int CW = $clog2(NPH + 1)
) (
    input  logic [NPH-1:0] en,
    output logic [CW-1:0]  edges
);
    always_comb begin
        edges = '0;
        for (int k = 0; k < NPH; k++) begin
            edges = edges + CW'(en[k]);
        end
    end
endmodule

// File: rtl/phsq_ctrl.sv
module phsq_ctrl
    import phsq_pkg::*;
#(
    parameter int NW      = 8,
    parameter int DW      = 8,
    parameter int AW      = DW + 3,
    parameter int RST_NUM = 2,
    parameter int RST_DEN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [NW-1:0] wr_num,
    input  logic [DW-1:0] wr_den,
    input  logic [AW-1:0] acc_nxt,
    output logic [AW-1:0] acc_q,
    output logic [NW-1:0] num_act,
    output logic [AW-1:0] span,
    output logic          seq_first,
    output logic          cfg_err
);
    seq_state_e    st_q, st_nx;
    logic [DW-1:0] den_act;
    logic [NW-1:0] num_pend;
    logic [DW-1:0] den_pend;
    logic [DW-1:0] pcnt;
    logic          last;
    logic          wr_ok;

    assign wr_ok = wr_en && (wr_den != '0) &&
                   (AW'(wr_num) <= AW'({wr_den, 2'b00}));
    assign last  = (pcnt == den_act - DW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_STEADY;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_STEADY: if (wr_ok && !last) st_nx = ST_ARMED;
            ST_ARMED:  if (last)           st_nx = ST_STEADY;
            default:                       st_nx = ST_STEADY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_act  <= NW'(RST_NUM);
            den_act  <= DW'(RST_DEN);
            num_pend <= NW'(RST_NUM);
            den_pend <= DW'(RST_DEN);
            pcnt     <= '0;
            acc_q    <= '0;
            cfg_err  <= 1'b0;
        end else begin
            if (wr_en) cfg_err <= !wr_ok;
            if (wr_ok) begin
                num_pend <= wr_num;
                den_pend <= wr_den;
            end
            if (last) begin
                pcnt  <= '0;
                acc_q <= '0;
                if (wr_ok) begin
                    num_act <= wr_num;
                    den_act <= wr_den;
                end else if (st_q == ST_ARMED) begin
                    num_act <= num_pend;
                    den_act <= den_pend;
                end
            end else begin
                pcnt  <= pcnt + DW'(1);
                acc_q <= acc_nxt;
            end
        end
    end

    always_comb begin
        seq_first = (pcnt == '0);
        span      = AW'({den_act, 2'b00});
    end

    // R3: the accumulator returns to zero at the end of each sequence
    p_seq_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> (acc_nxt == '0));
    // R4: a sequence start always follows the last period
    p_first_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> seq_first);
    // R5: the ratio only changes at a boundary
    p_hold_ratio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> ($stable(num_act) && $stable(den_act)));
    // R6: an illegal write raises the flag and never reaches the active ratio
    p_flag_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok) |=> cfg_err);
    p_den_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        den_act != '0);
    // R7: a legal write clears the flag
    p_clear_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !cfg_err);
endmodule

// File: rtl/phase_seq_synth.sv
module phase_seq_synth
    import phsq_pkg::*;
#(
    parameter int NW      = 8,
    parameter int DW      = 8,
    parameter int RST_NUM = 2,
    parameter int RST_DEN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [NW-1:0] cfg_num,
    input  logic [DW-1:0] cfg_den,
    output logic [3:0]    phase_en,
    output logic          seq_first,
    output logic          cfg_err,
    output logic [2:0]    edge_cnt
);
    localparam int AW = DW + 3;

    logic [AW-1:0] acc_q, acc_nxt, span;
    logic [NW-1:0] num_act;

    phsq_ctrl #(.NW(NW), .DW(DW), .AW(AW), .RST_NUM(RST_NUM), .RST_DEN(RST_DEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_num(cfg_num), .wr_den(cfg_den),
        .acc_nxt(acc_nxt), .acc_q(acc_q), .num_act(num_act), .span(span),
        .seq_first(seq_first), .cfg_err(cfg_err)
    );

    phsq_stepper #(.NW(NW), .AW(AW)) u_step (
        .acc_in(acc_q), .num(num_act), .span(span), .en(phase_en), .acc_out(acc_nxt)
    );

    phsq_combiner #(.CW(3)) u_comb (
        .en(phase_en), .edges(edge_cnt)
    );

    // R2: the accumulator stays below one full sequence span
    p_acc_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < span);
endmodule

// File: tb/phase_seq_synth_test.sv
module phase_seq_synth_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int V_NUM [NV] = '{1, 4, 3, 5, 0, 7, 1, 12};
    localparam int V_DEN [NV] = '{1, 1, 2, 3, 5, 2, 7, 3};
    localparam int V_REP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_num = '0;
    logic [7:0] cfg_den = '0;
    logic [3:0] phase_en;
    logic       seq_first, cfg_err;
    logic [2:0] edge_cnt;

    int compared = 0;
    int mismatched = 0;

    phase_seq_synth uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_num(cfg_num), .cfg_den(cfg_den),
        .phase_en(phase_en), .seq_first(seq_first), .cfg_err(cfg_err), .edge_cnt(edge_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int n, input int d);
        @(negedge clk);
        cfg_num = 8'(n); cfg_den = 8'(d); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_first();
        while (!seq_first) @(negedge clk);
    endtask

    task automatic measure(input int den, input int reps,
                           output int bits, output int edges, output int misplaced);
        bits = 0; edges = 0; misplaced = 0;
        for (int p = 0; p < den * reps; p++) begin
            bits  += $countones(phase_en);
            edges += int'(edge_cnt);
            if (seq_first != ((p % den) == 0)) misplaced++;
            @(negedge clk);
        end
        if (!seq_first) misplaced++;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        mismatched++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int bits, edges, mis, per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset ratio 2/1
        chk("R1 phase_en", int'(phase_en), 4'b1010);
        chk("R1 seq_first", int'(seq_first), 1);
        chk("R1 cfg_err", int'(cfg_err), 0);
        chk("R9 edge_cnt at reset", int'(edge_cnt), 2);

        // table walk: R3, R4, R9
        for (int v = 0; v < NV; v++) begin
            write_cfg(V_NUM[v], V_DEN[v]);
            wait_first();
            measure(V_DEN[v], V_REP, bits, edges, mis);
            chk($sformatf("R3 bits %0d/%0d", V_NUM[v], V_DEN[v]), bits, V_NUM[v] * V_REP);
            chk($sformatf("R9 edges %0d/%0d", V_NUM[v], V_DEN[v]), edges, V_NUM[v] * V_REP);
            chk($sformatf("R4 markers %0d/%0d", V_NUM[v], V_DEN[v]), mis, 0);
        end

        // R2: exact patterns for 3/2 and 5/3
        write_cfg(3, 2);
        wait_first();
        chk("R2 3/2 p0", int'(phase_en), 4'b0100);
        @(negedge clk);
        chk("R2 3/2 p1", int'(phase_en), 4'b1010);
        write_cfg(5, 3);
        wait_first();
        chk("R2 5/3 p0", int'(phase_en), 4'b0100);
        @(negedge clk);
        chk("R2 5/3 p1", int'(phase_en), 4'b1001);
        @(negedge clk);
        chk("R2 5/3 p2", int'(phase_en), 4'b1010);

        // R5: mid-sequence change keeps the old sequence intact
        write_cfg(1, 7);
        wait_first();
        bits = 0; per = 0;
        repeat (3) begin bits += $countones(phase_en); per++; @(negedge clk); end
        bits += $countones(phase_en); per++;
        cfg_num = 8'd4; cfg_den = 8'd1; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        while (!seq_first) begin bits += $countones(phase_en); per++; @(negedge clk); end
        chk("R5 old periods", per, 7);
        chk("R5 old bits", bits, 1);
        chk("R5 new word", int'(phase_en), 4'b1111);

        // R5: write during the last period applies next period
        write_cfg(3, 2);
        wait_first();
        @(negedge clk);
        cfg_num = 8'd2; cfg_den = 8'd1; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R5 last-period seq_first", int'(seq_first), 1);
        chk("R5 last-period word", int'(phase_en), 4'b1010);

        // R8: second pending write wins
        write_cfg(1, 7);
        wait_first();
        write_cfg(4, 1);
        write_cfg(0, 1);
        wait_first();
        chk("R8 replaced word", int'(phase_en), 4'b0000);

        // R6: illegal writes ignored, R7: legal write clears flag
        write_cfg(3, 2);
        wait_first();
        write_cfg(1, 0);
        chk("R6 den zero flag", int'(cfg_err), 1);
        write_cfg(9, 2);
        chk("R6 too many flag", int'(cfg_err), 1);
        wait_first();
        measure(2, 2, bits, edges, mis);
        chk("R6 ratio kept", bits, 6);
        chk("R6 markers kept", mis, 0);
        write_cfg(8, 2);
        chk("R7 flag cleared", int'(cfg_err), 0);
        wait_first();
        chk("R6 limit 8/2 word", int'(phase_en), 4'b1111);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule